// File: doc/BRIEF.md
# Packet-Mode I2C Command Front End

This block turns 32-bit request packets written by a host into byte-level commands for an I2C master engine. The host pushes three header words into a transmit packet FIFO: an identification word that carries a packet tag, a length word, and a transfer word that holds the slave address byte, the direction and an interrupt-enable flag. For a write, payload words follow. The front end unpacks each payload word into bytes for the engine. For a read, it packs the bytes it receives into 32-bit words and places them in a receive FIFO.

The block counts the bytes it moves and reports the result in two places: a packet status register, and a write-one-to-clear interrupt status register that drives a masked interrupt line. An address that is not acknowledged aborts the packet. A data byte that is not acknowledged, a lost arbitration or an engine timeout also aborts it. On abort, the remaining payload words of that packet are discarded, so the next packet starts on a header. The engine takes one command at a time. Each command is held on `cmd_*` until the engine returns a one-cycle `rsp_valid`.

Top module: `pkt_i2c_frontend`

Register map (word addresses on `host_addr`):
- 0: configuration. Bit 0 is packet enable. Bit 1 selects the newer master sequencer.
- 1: transmit FIFO push (write only).
- 2: receive FIFO pop (read only).
- 3: FIFO status.
- 4: packet status.
- 5: interrupt status (write one to clear).
- 6: interrupt mask.

Reads return data one cycle after `host_rd`.

## Requirements
- R1: A new packet starts only when configuration bits 0 and 1 are both set. While either bit is clear, pushed words stay in the transmit FIFO and no engine command is issued.
- R2: Bits 23:16 of header word 0 become the packet tag in status bits 23:16. Bits 7:0 of header word 2 are sent as the address command: the 7-bit address shifted left, with bit 0 = 1 for a read. Bit 19 of word 2 selects read, and bit 17 is the packet's interrupt enable.
- R3: Bits 11:0 of header word 1 hold the byte count minus one, so a value of N moves N+1 bytes. The last command of a packet has `cmd_last` = 1.
- R4: Write payload bytes go to the engine little-endian: bits 7:0 of a word first, then 15:8, then 23:16, then 31:24. Unused upper bytes of the final word are not sent.
- R5: Read bytes are packed little-endian into receive FIFO words. A partial final word has zero in its unused upper bytes.
- R6: The FIFO status register gives the transmit FIFO free-entry count in bits 7:4 and the receive FIFO filled-entry count in bits 3:0. After reset it reads 0x80.
- R7: Packet status fields are: bit 24 complete, 23:16 tag, 15:4 bytes moved, bit 3 address not acknowledged, bit 2 data not acknowledged, bit 1 arbitration lost, bit 0 busy. Busy is set from the pop of header word 0 until the packet completes, and complete is never set together with busy.
- R8: An address not acknowledged moves no payload byte. All payload words of that write are discarded, and the packet finishes with status bits 3 and 24 set.
- R9: A data byte not acknowledged stops the write. The bytes-moved count excludes the refused byte, the rest of the payload words are discarded, and status bit 2 is set.
- R10: Interrupt status bit 0 means complete, bit 1 means not acknowledged, bit 2 means arbitration lost and bit 3 means timeout. Writing a one to a bit clears it. Writing a zero to a bit leaves it unchanged.
- R11: `irq` is high when an interrupt status bit is set and its mask bit is set. For bit 0 (complete), the packet's interrupt-enable bit must also be set.
- R12: Lost arbitration or an engine timeout on any command aborts the packet the same way as R8. It sets interrupt status bit 2 or bit 3 respectively, and lost arbitration also sets packet status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Register word address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid one cycle after `host_rd` |
| irq | output | 1 | Masked interrupt request |
| cmd_valid | output | 1 | Engine command pending |
| cmd_kind | output | 2 | 0 = address, 1 = write byte, 2 = read byte |
| cmd_data | output | 8 | Address or write byte |
| cmd_last | output | 1 | Final data byte of the packet |
| rsp_valid | input | 1 | Engine completion pulse |
| rsp_data | input | 8 | Byte read from the bus |
| rsp_nack | input | 1 | Slave did not acknowledge |
| rsp_arb | input | 1 | Arbitration lost |
| rsp_tmo | input | 1 | Engine timeout |

## Verification
The bench targets these corner cases and the symptom each would show in a faulty design:
- Length field. A design that treats the field as a plain count, rather than count minus one, sends one byte too many.
- Partial final word. A design that loses track of it sends stale upper bytes, or leaves stale bytes in the last receive word.
- Discarding after an abort. If the discard after a refused address or data byte is missing, leftover payload words are parsed as the next header. The bench sees this as a transmit free count below the depth.
- Interrupt-enable gating. A design that does not gate the completion interrupt by the header's enable bit raises `irq` for a packet that opted out.
- Start gating. A design that starts on only one of the two configuration bits issues engine commands that should never appear.

// File: rtl/pi2c_pkg.sv
package pi2c_pkg;
  localparam int LEN_W    = 12;
  localparam int TAG_LSB  = 16;
  localparam int HDR_IE   = 17;
  localparam int HDR_RD   = 19;

  localparam int REG_CFG   = 0;
  localparam int REG_TXF   = 1;
  localparam int REG_RXF   = 2;
  localparam int REG_FSTAT = 3;
  localparam int REG_PSTAT = 4;
  localparam int REG_ISTAT = 5;
  localparam int REG_IMASK = 6;

  typedef enum logic [1:0] {
    CMD_ADDR = 2'd0,
    CMD_WR   = 2'd1,
    CMD_RD   = 2'd2
  } cmd_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_H1, S_H2, S_ADR, S_WLOAD, S_WBYTE, S_RBYTE, S_DRAIN, S_FIN
  } pstate_e;
endpackage

// File: rtl/pi2c_fifo.sv
module pi2c_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pi2c_parser.sv
module pi2c_parser
  import pi2c_pkg::*;
#(
  parameter int DW = 32,
  localparam int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [DW-1:0] tx_word,
  input  logic          tx_empty,
  output logic          tx_pop,
  input  logic          rx_full,
  output logic          rx_push,
  output logic [DW-1:0] rx_word,
  output logic          cmd_valid,
  output logic [1:0]    cmd_kind,
  output logic [7:0]    cmd_data,
  output logic          cmd_last,
  input  logic          rsp_valid,
  input  logic [7:0]    rsp_data,
  input  logic          rsp_nack,
  input  logic          rsp_arb,
  input  logic          rsp_tmo,
  output logic          busy,
  output logic          done,
  output logic [7:0]    tag,
  output logic [LW-1:0] bytecnt,
  output logic          nack_a,
  output logic          nack_d,
  output logic          arb_lost,
  output logic          ie,
  output logic          ev_done,
  output logic          ev_nack,
  output logic          ev_arb,
  output logic          ev_tmo
);
  pstate_e       st;
  logic [LW-1:0] remain, words_left;
  logic [1:0]    lane;
  logic [DW-1:0] wbuf, rbuf;
  logic [7:0]    addr_q;
  logic          rd_q, issued;
  logic          rsp_take, need_push, fail_any;

  assign need_push = (lane == 2'd3) || (remain == '0);
  assign rsp_take  = issued && rsp_valid &&
                     (st == S_ADR || st == S_WBYTE || st == S_RBYTE);
  assign fail_any  = rsp_nack || rsp_arb || rsp_tmo;
  assign ev_done   = (st == S_FIN);
  assign ev_nack   = rsp_take && rsp_nack && (st != S_RBYTE);
  assign ev_arb    = rsp_take && rsp_arb;
  assign ev_tmo    = rsp_take && rsp_tmo;
  assign rx_push   = (st == S_RBYTE) && rsp_take && !(rsp_arb || rsp_tmo) && need_push;

  always_comb begin
    rx_word = rbuf;
    rx_word[{lane, 3'b000} +: 8] = rsp_data;
  end

  always_comb begin
    case (st)
      S_IDLE:                 tx_pop = enable && !tx_empty;
      S_H1, S_H2, S_WLOAD:    tx_pop = !tx_empty;
      S_DRAIN:                tx_pop = !tx_empty && (words_left != '0);
      default:                tx_pop = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      {busy, done, nack_a, nack_d, arb_lost, ie, rd_q, issued} <= '0;
      {cmd_valid, cmd_last} <= '0;
      cmd_kind   <= CMD_ADDR;
      cmd_data   <= '0;
      tag        <= '0;
      bytecnt    <= '0;
      remain     <= '0;
      words_left <= '0;
      lane       <= '0;
      wbuf       <= '0;
      rbuf       <= '0;
      addr_q     <= '0;
    end else begin
      case (st)
        S_IDLE: if (tx_pop) begin
          tag      <= tx_word[TAG_LSB +: 8];
          busy     <= 1'b1;
          done     <= 1'b0;
          nack_a   <= 1'b0;
          nack_d   <= 1'b0;
          arb_lost <= 1'b0;
          bytecnt  <= '0;
          st       <= S_H1;
        end
        S_H1: if (tx_pop) begin
          remain     <= tx_word[LW-1:0];
          words_left <= (tx_word[LW-1:0] >> 2) + 1'b1;
          st         <= S_H2;
        end
        S_H2: if (tx_pop) begin
          rd_q   <= tx_word[HDR_RD];
          ie     <= tx_word[HDR_IE];
          addr_q <= tx_word[7:0];
          if (tx_word[HDR_RD]) words_left <= '0;
          issued <= 1'b0;
          st     <= S_ADR;
        end
        S_ADR: begin
          if (!issued) begin
            cmd_valid <= 1'b1;
            cmd_kind  <= CMD_ADDR;
            cmd_data  <= addr_q;
            cmd_last  <= 1'b0;
            issued    <= 1'b1;
          end else if (rsp_valid) begin
            cmd_valid <= 1'b0;
            issued    <= 1'b0;
            lane      <= '0;
            rbuf      <= '0;
            if (fail_any) begin
              nack_a   <= rsp_nack;
              arb_lost <= rsp_arb;
              st       <= S_DRAIN;
            end else begin
              st <= rd_q ? S_RBYTE : S_WLOAD;
            end
          end
        end
        S_WLOAD: if (tx_pop) begin
          wbuf       <= tx_word;
          words_left <= words_left - 1'b1;
          lane       <= '0;
          issued     <= 1'b0;
          st         <= S_WBYTE;
        end
        S_WBYTE: begin
          if (!issued) begin
            cmd_valid <= 1'b1;
            cmd_kind  <= CMD_WR;
            cmd_data  <= wbuf[{lane, 3'b000} +: 8];
            cmd_last  <= (remain == '0);
            issued    <= 1'b1;
          end else if (rsp_valid) begin
            cmd_valid <= 1'b0;
            issued    <= 1'b0;
            if (fail_any) begin
              nack_d   <= rsp_nack;
              arb_lost <= rsp_arb;
              st       <= S_DRAIN;
            end else begin
              bytecnt <= bytecnt + 1'b1;
              if (remain == '0) st <= S_FIN;
              else begin
                remain <= remain - 1'b1;
                if (lane == 2'd3) st <= S_WLOAD;
                else lane <= lane + 1'b1;
              end
            end
          end
        end
        S_RBYTE: begin
          if (!issued) begin
            if (!(need_push && rx_full)) begin
              cmd_valid <= 1'b1;
              cmd_kind  <= CMD_RD;
              cmd_data  <= '0;
              cmd_last  <= (remain == '0);
              issued    <= 1'b1;
            end
          end else if (rsp_valid) begin
            cmd_valid <= 1'b0;
            issued    <= 1'b0;
            if (rsp_arb || rsp_tmo) begin
              arb_lost <= rsp_arb;
              st       <= S_DRAIN;
            end else begin
              bytecnt <= bytecnt + 1'b1;
              if (need_push) begin
                rbuf <= '0;
                lane <= '0;
              end else begin
                rbuf <= rx_word;
                lane <= lane + 1'b1;
              end
              if (remain == '0) st <= S_FIN;
              else remain <= remain - 1'b1;
            end
          end
        end
        S_DRAIN: begin
          if (words_left == '0) st <= S_FIN;
          else if (tx_pop) words_left <= words_left - 1'b1;
        end
        S_FIN: begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pi2c_regs.sv
module pi2c_regs
  import pi2c_pkg::*;
#(
  parameter int AW    = 3,
  parameter int DW    = 32,
  parameter int TX_CW = 4,
  parameter int RX_CW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [AW-1:0]    host_addr,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  output logic             irq,
  output logic             enable,
  output logic             tx_push,
  output logic             rx_pop,
  input  logic [TX_CW-1:0] tx_free,
  input  logic [RX_CW-1:0] rx_cnt,
  input  logic [DW-1:0]    rx_head,
  input  logic             rx_empty,
  input  logic             p_busy,
  input  logic             p_done,
  input  logic [7:0]       p_tag,
  input  logic [LEN_W-1:0] p_cnt,
  input  logic             p_na,
  input  logic             p_nd,
  input  logic             p_arb,
  input  logic             p_ie,
  input  logic             ev_done,
  input  logic             ev_nack,
  input  logic             ev_arb,
  input  logic             ev_tmo,
  output logic [3:0]       int_stat,
  output logic [3:0]       int_mask
);
  logic [1:0]    cfg;
  logic [3:0]    clr, set;
  logic [DW-1:0] fstat, pstat;

  assign enable  = cfg[0] && cfg[1];
  assign tx_push = host_wr && (host_addr == AW'(REG_TXF));
  assign rx_pop  = host_rd && (host_addr == AW'(REG_RXF));
  assign clr     = (host_wr && host_addr == AW'(REG_ISTAT)) ? host_wdata[3:0] : 4'b0;
  assign set     = {ev_tmo, ev_arb, ev_nack, ev_done};
  assign fstat   = {{(DW-8){1'b0}}, 4'(tx_free), 4'(rx_cnt)};
  assign pstat   = {{(DW-25){1'b0}}, p_done, p_tag, p_cnt, p_na, p_nd, p_arb, p_busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg        <= '0;
      int_stat   <= '0;
      int_mask   <= '0;
      irq        <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (host_wr && host_addr == AW'(REG_CFG))   cfg      <= host_wdata[1:0];
      if (host_wr && host_addr == AW'(REG_IMASK)) int_mask <= host_wdata[3:0];
      int_stat <= (int_stat & ~clr) | set;
      irq      <= |(int_stat & int_mask & {3'b111, p_ie});
      if (host_rd) begin
        case (host_addr)
          AW'(REG_CFG):   host_rdata <= {{(DW-2){1'b0}}, cfg};
          AW'(REG_RXF):   host_rdata <= rx_empty ? '0 : rx_head;
          AW'(REG_FSTAT): host_rdata <= fstat;
          AW'(REG_PSTAT): host_rdata <= pstat;
          AW'(REG_ISTAT): host_rdata <= {{(DW-4){1'b0}}, int_stat};
          AW'(REG_IMASK): host_rdata <= {{(DW-4){1'b0}}, int_mask};
          default:        host_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pkt_i2c_frontend.sv
module pkt_i2c_frontend
  import pi2c_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  localparam int TX_CW   = $clog2(TX_DEPTH + 1),
  localparam int RX_CW   = $clog2(RX_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [2:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        irq,
  output logic        cmd_valid,
  output logic [1:0]  cmd_kind,
  output logic [7:0]  cmd_data,
  output logic        cmd_last,
  input  logic        rsp_valid,
  input  logic [7:0]  rsp_data,
  input  logic        rsp_nack,
  input  logic        rsp_arb,
  input  logic        rsp_tmo
);
  logic             enable, tx_push, tx_pop, tx_empty, tx_full;
  logic             rx_push, rx_pop, rx_empty, rx_full;
  logic [31:0]      tx_word, rx_word, rx_head;
  logic [TX_CW-1:0] tx_cnt, tx_free;
  logic [RX_CW-1:0] rx_cnt;
  logic             p_busy, p_done, p_na, p_nd, p_arb, p_ie;
  logic [7:0]       p_tag;
  logic [LEN_W-1:0] p_cnt;
  logic             ev_done, ev_nack, ev_arb, ev_tmo;
  logic [3:0]       int_stat, int_mask;

  assign tx_free = TX_CW'(TX_DEPTH) - tx_cnt;

  pi2c_fifo #(.W(32), .DEPTH(TX_DEPTH)) u_txf (
    .clk, .rst, .push(tx_push), .din(host_wdata), .pop(tx_pop),
    .dout(tx_word), .empty(tx_empty), .full(tx_full), .count(tx_cnt));

  pi2c_fifo #(.W(32), .DEPTH(RX_DEPTH)) u_rxf (
    .clk, .rst, .push(rx_push), .din(rx_word), .pop(rx_pop),
    .dout(rx_head), .empty(rx_empty), .full(rx_full), .count(rx_cnt));

  pi2c_parser #(.DW(32)) u_prs (
    .clk, .rst, .enable, .tx_word, .tx_empty, .tx_pop, .rx_full, .rx_push, .rx_word,
    .cmd_valid, .cmd_kind, .cmd_data, .cmd_last,
    .rsp_valid, .rsp_data, .rsp_nack, .rsp_arb, .rsp_tmo,
    .busy(p_busy), .done(p_done), .tag(p_tag), .bytecnt(p_cnt),
    .nack_a(p_na), .nack_d(p_nd), .arb_lost(p_arb), .ie(p_ie),
    .ev_done, .ev_nack, .ev_arb, .ev_tmo);

  pi2c_regs #(.AW(3), .DW(32), .TX_CW(TX_CW), .RX_CW(RX_CW)) u_regs (
    .clk, .rst, .host_wr, .host_rd, .host_addr, .host_wdata, .host_rdata, .irq,
    .enable, .tx_push, .rx_pop, .tx_free, .rx_cnt, .rx_head, .rx_empty,
    .p_busy, .p_done, .p_tag, .p_cnt, .p_na, .p_nd, .p_arb, .p_ie,
    .ev_done, .ev_nack, .ev_arb, .ev_tmo, .int_stat, .int_mask);
endmodule

// File: rtl/pi2c_checker.sv
module pi2c_checker #(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  localparam int TX_CW   = $clog2(TX_DEPTH + 1),
  localparam int RX_CW   = $clog2(RX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [7:0]       cmd_data,
  input logic             rsp_valid,
  input logic             p_busy,
  input logic             p_done,
  input logic [11:0]      p_cnt,
  input logic [TX_CW-1:0] tx_cnt,
  input logic [RX_CW-1:0] rx_cnt
);
  a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(p_busy && p_done));

  a_r1_cmd_only_in_packet: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> p_busy);

  a_r2_cmd_held: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !rsp_valid) |=> (cmd_valid && $stable(cmd_data)));

  a_r3_count_monotonic: assert property (@(posedge clk) disable iff (rst)
    (p_busy && $past(p_busy)) |-> (p_cnt >= $past(p_cnt)));

  a_r6_fifo_bounds: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt <= TX_CW'(TX_DEPTH)) && (rx_cnt <= RX_CW'(RX_DEPTH)));

  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(p_busy) |-> p_done);
endmodule

bind pkt_i2c_frontend pi2c_checker #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
  .rsp_valid(rsp_valid), .p_busy(p_busy), .p_done(p_done), .p_cnt(p_cnt),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt));

// File: tb/sim_pkt_i2c_frontend.sv
`timescale 1ns/1ps
module sim_pkt_i2c_frontend;
  logic        clk = 0, rst = 1;
  logic        host_wr = 0, host_rd = 0;
  logic [2:0]  host_addr = 0;
  logic [31:0] host_wdata = 0;
  logic [31:0] host_rdata;
  logic        irq, cmd_valid, cmd_last;
  logic [1:0]  cmd_kind;
  logic [7:0]  cmd_data;
  logic        rsp_valid = 0, rsp_nack = 0, rsp_arb = 0, rsp_tmo = 0;
  logic [7:0]  rsp_data = 0;

  int checks = 0, fails = 0;
  bit finished = 0;

  // engine behaviour knobs and logs
  bit   nack_addr = 0, arb_addr = 0, tmo_addr = 0;
  int   nack_data_at = -1;
  bit   pend = 0;
  int   ewait = 0;
  logic [1:0] pk;
  logic [7:0] addr_log[$];
  logic [7:0] wr_log[$];
  logic [7:0] rd_src[$];
  int   rd_cnt = 0, last_seen = 0;

  always #5 clk = ~clk;

  pkt_i2c_frontend u0 (.*);

  always @(negedge clk) begin
    rsp_valid = 0; rsp_nack = 0; rsp_arb = 0; rsp_tmo = 0;
    if (rst) begin
      pend = 0;
    end else if (cmd_valid && !pend) begin
      pend = 1; ewait = 2; pk = cmd_kind;
      if (cmd_last) last_seen++;
      if (cmd_kind == 2'd0) addr_log.push_back(cmd_data);
      else if (cmd_kind == 2'd1) wr_log.push_back(cmd_data);
    end else if (pend) begin
      ewait--;
      if (ewait == 0) begin
        pend = 0; rsp_valid = 1;
        if (pk == 2'd0) begin
          rsp_nack = nack_addr; rsp_arb = arb_addr; rsp_tmo = tmo_addr;
        end else if (pk == 2'd1) begin
          if (wr_log.size() - 1 == nack_data_at) rsp_nack = 1;
        end else begin
          rd_cnt++;
          rsp_data = (rd_src.size() > 0) ? rd_src.pop_front() : 8'h00;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input int a, input logic [31:0] d);
    @(negedge clk); host_wr = 1; host_addr = 3'(a); host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hr(input int a, output logic [31:0] d);
    @(negedge clk); host_rd = 1; host_addr = 3'(a);
    @(negedge clk); d = host_rdata; host_rd = 0;
  endtask

  function automatic logic [31:0] w0(input logic [7:0] tag);
    return (32'h2 << 28) | (32'(tag) << 16) | 32'h1;
  endfunction
  function automatic logic [31:0] w2(input logic [6:0] a, input bit rd, input bit ie);
    return (32'(ie) << 17) | (32'(rd) << 19) | 32'({a, rd});
  endfunction
  function automatic logic [31:0] pexp(input logic [7:0] tag, input int cnt,
                                        input bit na, input bit nd, input bit ar);
    return (32'h1 << 24) | (32'(tag) << 16) | (32'(cnt) << 4) |
           (32'(na) << 3) | (32'(nd) << 2) | (32'(ar) << 1);
  endfunction

  task automatic send(input logic [7:0] tag, input int n, input logic [6:0] a,
                      input bit rd, input bit ie);
    hw(1, w0(tag)); hw(1, 32'(n - 1)); hw(1, w2(a, rd, ie));
  endtask

  task automatic wait_done(input string req);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      hr(4, v);
      if (v[24]) return;
    end
    chk(0, req, v, 32'h01000000);
  endtask

  task automatic reset_logs();
    addr_log.delete(); wr_log.delete(); rd_src.delete();
    rd_cnt = 0; last_seen = 0;
    nack_addr = 0; arb_addr = 0; tmo_addr = 0; nack_data_at = -1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // reset state
    hr(3, v); chk(v == 32'h80, "R6 reset fifo status", v, 32'h80);
    hr(4, v); chk(v == 0, "R7 reset packet status", v, 0);
    hr(5, v); chk(v == 0, "R10 reset int status", v, 0);

    // R1: only one enable bit set, nothing moves
    reset_logs();
    hw(0, 32'h1);
    send(8'h3A, 1, 7'h50, 0, 0); hw(1, 32'hFFFF_FFA5);
    repeat (20) @(negedge clk);
    hr(3, v); chk(v[7:4] == 4, "R1 words held while disabled", v[7:4], 4);
    chk(addr_log.size() == 0, "R1 no command while disabled", addr_log.size(), 0);
    hw(0, 32'h3);
    wait_done("R1 packet after enable");
    chk(addr_log.size() == 1 && addr_log[0] == 8'hA0, "R2 write address byte",
        addr_log.size() ? addr_log[0] : 0, 8'hA0);
    chk(wr_log.size() == 1 && wr_log[0] == 8'hA5, "R4 single byte, upper ignored",
        wr_log.size(), 1);
    hr(4, v); chk(v == pexp(8'h3A, 1, 0, 0, 0), "R7 status after 1-byte write", v, pexp(8'h3A, 1, 0, 0, 0));

    // R3/R4: six byte write
    reset_logs();
    send(8'h11, 6, 7'h22, 0, 0); hw(1, 32'h4433_2211); hw(1, 32'hDDCC_6655);
    wait_done("R3 six byte write");
    chk(wr_log.size() == 6, "R3 N+1 bytes written", wr_log.size(), 6);
    for (int i = 0; i < 6 && i < wr_log.size(); i++)
      chk(wr_log[i] == 8'(8'h11 * (i + 1)), "R4 little-endian byte order", wr_log[i], 8'(8'h11 * (i + 1)));
    chk(last_seen == 1, "R3 single last marker", last_seen, 1);
    hr(4, v); chk(v == pexp(8'h11, 6, 0, 0, 0), "R7 byte count six", v, pexp(8'h11, 6, 0, 0, 0));

    // R5: five byte read
    reset_logs();
    rd_src = '{8'h9A, 8'hBC, 8'hDE, 8'hF0, 8'h12};
    send(8'h77, 5, 7'h3C, 1, 0);
    wait_done("R5 read");
    chk(addr_log.size() == 1 && addr_log[0] == 8'h79, "R2 read address byte",
        addr_log.size() ? addr_log[0] : 0, 8'h79);
    chk(rd_cnt == 5, "R3 five reads", rd_cnt, 5);
    hr(3, v); chk(v == 32'h82, "R6 rx count two", v, 32'h82);
    hr(2, v); chk(v == 32'hF0DE_BC9A, "R5 first rx word", v, 32'hF0DE_BC9A);
    hr(2, v); chk(v == 32'h0000_0012, "R5 partial rx word", v, 32'h12);
    hr(3, v); chk(v == 32'h80, "R6 fifos empty", v, 32'h80);

    // R8: address refused on a 9-byte write
    hw(5, 32'hF);
    reset_logs(); nack_addr = 1;
    send(8'h05, 9, 7'h10, 0, 0); hw(1, 32'h1); hw(1, 32'h2); hw(1, 32'h3);
    wait_done("R8 address nack");
    repeat (4) @(negedge clk);
    chk(wr_log.size() == 0, "R8 no payload after address nack", wr_log.size(), 0);
    hr(3, v); chk(v == 32'h80, "R8 payload words discarded", v, 32'h80);
    hr(4, v); chk(v == pexp(8'h05, 0, 1, 0, 0), "R8 status bits", v, pexp(8'h05, 0, 1, 0, 0));
    hr(5, v); chk(v == 32'h3, "R8 int nack and complete", v, 3);

    // R10: write one to clear, bit by bit
    hw(5, 32'h1); hr(5, v); chk(v == 32'h2, "R10 clear complete only", v, 2);
    hw(5, 32'h2); hr(5, v); chk(v == 32'h0, "R10 clear nack", v, 0);

    // R9: data refused on second byte
    reset_logs(); nack_data_at = 1;
    send(8'h66, 6, 7'h11, 0, 0); hw(1, 32'h0403_0201); hw(1, 32'h0000_0605);
    wait_done("R9 data nack");
    repeat (4) @(negedge clk);
    chk(wr_log.size() == 2, "R9 stop after refused byte", wr_log.size(), 2);
    hr(4, v); chk(v == pexp(8'h66, 1, 0, 1, 0), "R9 status", v, pexp(8'h66, 1, 0, 1, 0));
    hr(3, v); chk(v == 32'h80, "R9 rest discarded", v, 32'h80);

    // R7: busy seen mid-transfer
    hw(5, 32'hF);
    reset_logs();
    send(8'h42, 8, 7'h01, 0, 0); hw(1, 32'h0); hw(1, 32'h0);
    hr(4, v); chk(v[0] == 1 && v[24] == 0 && v[23:16] == 8'h42, "R7 busy during packet", v, 32'h00420001);
    wait_done("R7 finish");

    // R11: irq gating
    hw(5, 32'hF); hw(6, 32'h1);
    reset_logs();
    send(8'h01, 1, 7'h01, 0, 1); hw(1, 32'h0);
    wait_done("R11 ie packet");
    repeat (3) @(negedge clk);
    chk(irq == 1, "R11 irq on enabled completion", irq, 1);
    hw(5, 32'h1); repeat (3) @(negedge clk);
    chk(irq == 0, "R11 irq drops after clear", irq, 0);
    send(8'h02, 1, 7'h01, 0, 0); hw(1, 32'h0);
    wait_done("R11 no-ie packet");
    repeat (3) @(negedge clk);
    chk(irq == 0, "R11 completion gated by header", irq, 0);
    hw(6, 32'h2); reset_logs(); nack_addr = 1;
    send(8'h03, 1, 7'h01, 0, 0); hw(1, 32'h0);
    wait_done("R11 nack packet");
    repeat (3) @(negedge clk);
    chk(irq == 1, "R11 irq on masked-in nack", irq, 1);
    hw(6, 32'h0); hw(5, 32'hF);

    // R12: arbitration loss and timeout
    reset_logs(); arb_addr = 1;
    send(8'h0A, 4, 7'h01, 0, 0); hw(1, 32'h0);
    wait_done("R12 arb");
    hr(4, v); chk(v == pexp(8'h0A, 0, 0, 0, 1), "R12 arb status", v, pexp(8'h0A, 0, 0, 0, 1));
    hr(5, v); chk(v == 32'h5, "R12 arb int bits", v, 5);
    hw(5, 32'hF);
    reset_logs(); tmo_addr = 1;
    send(8'h0B, 2, 7'h01, 1, 0);
    wait_done("R12 timeout");
    hr(5, v); chk(v == 32'h9, "R12 timeout int bits", v, 9);
    hr(3, v); chk(v == 32'h80, "R12 fifos clean", v, 32'h80);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule